// File: doc/BRIEF.md
# Mode-Aware Peripheral Energy Tally

This block is an on-chip energy monitor placed next to a serial peripheral. It watches a stream of already-decoded peripheral operations and keeps a running estimate of the energy the peripheral has consumed. It tracks the peripheral's power mode with a four-state machine. Each accepted operation is charged a cost from a constant table. The table is indexed by three things: the mode in force before the operation, the operation itself, and a buffer-size setting. The same operation can therefore cost very different amounts depending on which direction enables came earlier.

The state machine has four states. IDLE (code 0) has both directions off. TX_ON (code 1) has only the transmitter on. RX_ON (code 2) has only the receiver on. DUPLEX (code 3) has both on. Bit 0 of the code means transmit enabled and bit 1 means receive enabled. Each accepted operation produces one named transition:
- T_CLEAR: the clear input forces IDLE.
- T_DROP: a reset operation returns to IDLE.
- T_ARM_TX: a transmit enable sets the transmit bit. IDLE goes to TX_ON and RX_ON goes to DUPLEX.
- T_ARM_RX: a receive enable sets the receive bit. IDLE goes to RX_ON and TX_ON goes to DUPLEX.
- T_HOLD: the mode stays where it is. This covers data moves, undefined codes, enables already in force, and cycles with no operation.

The accumulated energy is an unsigned integer count of microjoules. It saturates at its maximum value.

Top module: `mode_energy_tally`

## Requirements
- R1: After reset, `mode_o` is 0 (IDLE) and `energy_o` is 0.
- R2: Operation code 0 (reset) moves the mode to IDLE from any state.
- R3: Operation code 1 (transmit enable) moves IDLE to TX_ON and RX_ON to DUPLEX. It leaves TX_ON and DUPLEX unchanged.
- R4: Operation code 2 (receive enable) moves IDLE to RX_ON and TX_ON to DUPLEX. It leaves RX_ON and DUPLEX unchanged.
- R5: Operation codes 3 (send) and 4 (receive) never change the mode.
- R6: An accepted operation adds the table cost for the mode held before that operation. Examples, for `size_sel` 0 to 3: send in TX_ON or DUPLEX costs 133/135/157/209, receive in RX_ON costs 73/83/93/111, send in IDLE costs 17/19/19/20, and reset in IDLE costs 11/13/14/14. The cost does not depend on any data.
- R7: The new total and the new mode appear on the clock edge that accepts `op_valid`, and are visible in the following cycle. With `op_valid` low, both outputs hold.
- R8: The total saturates at 2^ACC_W-1 and never wraps.
- R9: `clr` zeroes the total and forces IDLE on the next edge. It takes priority over a simultaneous operation.
- R10: Operation codes 5 to 7 add nothing and leave the mode unchanged.
- R11: `size_sel` values 0, 1, 2 and 3 select the 2, 4, 8 and 16 byte buffer columns of the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of total and mode |
| op_valid | input | 1 | Operation strobe, one operation per cycle |
| op_code | input | 3 | Operation code (0 reset, 1 tx enable, 2 rx enable, 3 send, 4 receive) |
| size_sel | input | 2 | Buffer-size column select |
| mode_o | output | 2 | Current power mode |
| energy_o | output | ACC_W | Accumulated energy in microjoules |

## Verification
The assertions assume that `op_code` and `size_sel` are meaningful only while `op_valid` is high. They also assume that `clr` may coincide with any operation. The assertions hold no matter how inputs behave between strobes.

The stimulus drives every input away from the clock edge and holds it for one full cycle. It covers undefined codes, clears that collide with operations, and runs long enough to drive a narrowed accumulator into saturation. Apart from those deliberate cases, it stays within the defined code range.

// File: rtl/energy_tally_pkg.sv
package energy_tally_pkg;

    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_TX   = 2'd1,
        M_RX   = 2'd2,
        M_DUP  = 2'd3
    } pmode_e;

    typedef enum logic [2:0] {
        T_CLEAR,
        T_DROP,
        T_ARM_TX,
        T_ARM_RX,
        T_HOLD
    } ptrans_e;

    localparam logic [2:0] OPC_RESET = 3'd0;
    localparam logic [2:0] OPC_ENTX  = 3'd1;
    localparam logic [2:0] OPC_ENRX  = 3'd2;
    localparam logic [2:0] OPC_SEND  = 3'd3;
    localparam logic [2:0] OPC_RECV  = 3'd4;

    // one table row: four buffer-size columns, column 0 in the low byte
    typedef logic [3:0][7:0] cost_row_t;

    function automatic cost_row_t mk_row(input int c2, input int c4, input int c8, input int c16);
        cost_row_t r;
        r[0] = 8'(c2);
        r[1] = 8'(c4);
        r[2] = 8'(c8);
        r[3] = 8'(c16);
        return r;
    endfunction

endpackage

// File: rtl/mode_tracker.sv
module mode_tracker
    import energy_tally_pkg::*;
#(
    parameter int OP_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            op_valid,
    input  logic [OP_W-1:0] op_code,
    output pmode_e          mode_q
);

    ptrans_e trans;
    pmode_e  mode_d;

    // transition selection
    always_comb begin
        trans = T_HOLD;
        if (clr) begin
            trans = T_CLEAR;
        end else if (op_valid) begin
            if (op_code == OP_W'(OPC_RESET))     trans = T_DROP;
            else if (op_code == OP_W'(OPC_ENTX)) trans = T_ARM_TX;
            else if (op_code == OP_W'(OPC_ENRX)) trans = T_ARM_RX;
            else                                 trans = T_HOLD;
        end
    end

    // next-state by current state and transition
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            M_IDLE: begin
                if (trans == T_ARM_TX)      mode_d = M_TX;
                else if (trans == T_ARM_RX) mode_d = M_RX;
                else                        mode_d = M_IDLE;
            end
            M_TX: begin
                if (trans == T_CLEAR || trans == T_DROP) mode_d = M_IDLE;
                else if (trans == T_ARM_RX)              mode_d = M_DUP;
                else                                     mode_d = M_TX;
            end
            M_RX: begin
                if (trans == T_CLEAR || trans == T_DROP) mode_d = M_IDLE;
                else if (trans == T_ARM_TX)              mode_d = M_DUP;
                else                                     mode_d = M_RX;
            end
            M_DUP: begin
                if (trans == T_CLEAR || trans == T_DROP) mode_d = M_IDLE;
                else                                     mode_d = M_DUP;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= M_IDLE;
        else        mode_q <= mode_d;
    end

    p_drop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !clr && op_code == OP_W'(OPC_RESET)) |=> (mode_q == M_IDLE));

    p_arm_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !clr && op_code == OP_W'(OPC_ENTX)) |=> mode_q[0]);

    p_arm_rx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !clr && op_code == OP_W'(OPC_ENRX)) |=> mode_q[1]);

    p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !clr && (op_code == OP_W'(OPC_SEND) || op_code == OP_W'(OPC_RECV)))
        |=> $stable(mode_q));

    p_clear_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (mode_q == M_IDLE));

endmodule

// File: rtl/cost_rom.sv
module cost_rom
    import energy_tally_pkg::*;
#(
    parameter int OP_W   = 3,
    parameter int SZ_W   = 2,
    parameter int COST_W = 8
) (
    input  pmode_e            mode,
    input  logic [OP_W-1:0]   op_code,
    input  logic [SZ_W-1:0]   size_sel,
    output logic [COST_W-1:0] cost
);

    localparam int NCOL = 1 << SZ_W;

    cost_row_t row;

    always_comb begin
        row = '0;
        unique case (mode)
            M_IDLE: begin
                case (op_code)
                    OP_W'(OPC_RESET): row = mk_row(11, 13, 14, 14);
                    OP_W'(OPC_ENTX):  row = mk_row(27, 32, 31, 31);
                    OP_W'(OPC_ENRX):  row = mk_row(17, 18, 19, 18);
                    OP_W'(OPC_SEND):  row = mk_row(17, 19, 19, 20);
                    OP_W'(OPC_RECV):  row = mk_row(14, 15, 17, 18);
                    default:          row = '0;
                endcase
            end
            M_TX: begin
                case (op_code)
                    OP_W'(OPC_RESET): row = mk_row(13, 13, 14, 14);
                    OP_W'(OPC_ENTX):  row = mk_row(23, 23, 22, 24);
                    OP_W'(OPC_ENRX):  row = mk_row(19, 20, 19, 19);
                    OP_W'(OPC_SEND):  row = mk_row(133, 135, 157, 209);
                    OP_W'(OPC_RECV):  row = mk_row(14, 16, 18, 18);
                    default:          row = '0;
                endcase
            end
            M_RX: begin
                case (op_code)
                    OP_W'(OPC_RESET): row = mk_row(13, 14, 15, 15);
                    OP_W'(OPC_ENTX):  row = mk_row(22, 22, 21, 21);
                    OP_W'(OPC_ENRX):  row = mk_row(18, 19, 18, 18);
                    OP_W'(OPC_SEND):  row = mk_row(19, 19, 21, 23);
                    OP_W'(OPC_RECV):  row = mk_row(73, 83, 93, 111);
                    default:          row = '0;
                endcase
            end
            M_DUP: begin
                case (op_code)
                    OP_W'(OPC_RESET): row = mk_row(13, 13, 14, 14);
                    OP_W'(OPC_ENTX):  row = mk_row(21, 22, 21, 21);
                    OP_W'(OPC_ENRX):  row = mk_row(19, 19, 19, 19);
                    OP_W'(OPC_SEND):  row = mk_row(133, 135, 157, 209);
                    OP_W'(OPC_RECV):  row = mk_row(74, 81, 93, 107);
                    default:          row = '0;
                endcase
            end
        endcase
    end

    // column select, one comparator per column
    logic [NCOL-1:0][COST_W-1:0] col_val;
    for (genvar c = 0; c < NCOL; c++) begin : g_col
        if (c < 4) begin : g_real
            assign col_val[c] = COST_W'(row[c]);
        end else begin : g_pad
            assign col_val[c] = '0;
        end
    end

    assign cost = col_val[size_sel];

endmodule

// File: rtl/sat_accum.sv
module sat_accum #(
    parameter int ACC_W  = 32,
    parameter int COST_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add_en,
    input  logic [COST_W-1:0] addend,
    output logic [ACC_W-1:0] acc_q
);

    localparam int SUM_W = ACC_W + 1;

    logic [SUM_W-1:0] sum_wide;
    logic [ACC_W-1:0] acc_d;

    always_comb begin
        sum_wide = {1'b0, acc_q} + SUM_W'(addend);
        if (clr)                acc_d = '0;
        else if (!add_en)       acc_d = acc_q;
        else if (sum_wide[ACC_W]) acc_d = '1;
        else                    acc_d = sum_wide[ACC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (acc_q >= $past(acc_q)));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !add_en) |=> $stable(acc_q));

    p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0));

endmodule

// File: rtl/mode_energy_tally.sv
module mode_energy_tally
    import energy_tally_pkg::*;
#(
    parameter int ACC_W  = 32,
    parameter int COST_W = 8,
    parameter int OP_W   = 3,
    parameter int SZ_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             op_valid,
    input  logic [OP_W-1:0]  op_code,
    input  logic [SZ_W-1:0]  size_sel,
    output logic [1:0]       mode_o,
    output logic [ACC_W-1:0] energy_o
);

    pmode_e            mode_q;
    logic [COST_W-1:0] cost;

    mode_tracker #(.OP_W(OP_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .op_valid (op_valid),
        .op_code  (op_code),
        .mode_q   (mode_q)
    );

    cost_rom #(.OP_W(OP_W), .SZ_W(SZ_W), .COST_W(COST_W)) u_rom (
        .mode     (mode_q),
        .op_code  (op_code),
        .size_sel (size_sel),
        .cost     (cost)
    );

    sat_accum #(.ACC_W(ACC_W), .COST_W(COST_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .add_en (op_valid),
        .addend (cost),
        .acc_q  (energy_o)
    );

    assign mode_o = mode_q;

    p_undef_inert_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !clr && op_code > OP_W'(OPC_RECV)) |=> ($stable(energy_o) && $stable(mode_o)));

    p_send_tx_cost_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !clr && op_code == OP_W'(OPC_SEND) && mode_o == 2'd1 && size_sel == SZ_W'(3)
         && energy_o < {ACC_W{1'b1}} - ACC_W'(300))
        |=> (energy_o == $past(energy_o) + ACC_W'(209)));

endmodule

// File: tb/sim_mode_energy_tally.sv
`timescale 1ns/100ps
module sim_mode_energy_tally;

    localparam int ACC_W = 16;
    localparam int MAXV  = (1 << ACC_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic op_valid = 1'b0;
    logic [2:0] op_code = 3'd0;
    logic [1:0] size_sel = 2'd0;
    logic [1:0] mode_o;
    logic [ACC_W-1:0] energy_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int ref_mode = 0;
    int ref_total = 0;

    always #2.5 clk = ~clk;

    mode_energy_tally #(.ACC_W(ACC_W)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .op_valid(op_valid),
        .op_code(op_code), .size_sel(size_sel), .mode_o(mode_o), .energy_o(energy_o)
    );

    function automatic int pick(input int a, input int b, input int c, input int d, input int s);
        case (s)
            0: return a;
            1: return b;
            2: return c;
            default: return d;
        endcase
    endfunction

    // expected cost: mode bit0 = tx on, bit1 = rx on
    function automatic int exp_cost(input int m, input int o, input int s);
        case (m)
            0: case (o)
                0: return pick(11, 13, 14, 14, s);
                1: return pick(27, 32, 31, 31, s);
                2: return pick(17, 18, 19, 18, s);
                3: return pick(17, 19, 19, 20, s);
                4: return pick(14, 15, 17, 18, s);
                default: return 0;
            endcase
            1: case (o)
                0: return pick(13, 13, 14, 14, s);
                1: return pick(23, 23, 22, 24, s);
                2: return pick(19, 20, 19, 19, s);
                3: return pick(133, 135, 157, 209, s);
                4: return pick(14, 16, 18, 18, s);
                default: return 0;
            endcase
            2: case (o)
                0: return pick(13, 14, 15, 15, s);
                1: return pick(22, 22, 21, 21, s);
                2: return pick(18, 19, 18, 18, s);
                3: return pick(19, 19, 21, 23, s);
                4: return pick(73, 83, 93, 111, s);
                default: return 0;
            endcase
            default: case (o)
                0: return pick(13, 13, 14, 14, s);
                1: return pick(21, 22, 21, 21, s);
                2: return pick(19, 19, 19, 19, s);
                3: return pick(133, 135, 157, 209, s);
                4: return pick(74, 81, 93, 107, s);
                default: return 0;
            endcase
        endcase
    endfunction

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            ref_mode <= 0;
            ref_total <= 0;
        end else if (clr) begin
            ref_mode <= 0;
            ref_total <= 0;
        end else if (op_valid) begin
            ref_total <= (ref_total + exp_cost(ref_mode, int'(op_code), int'(size_sel)) > MAXV)
                         ? MAXV : ref_total + exp_cost(ref_mode, int'(op_code), int'(size_sel));
            case (int'(op_code))
                0: ref_mode <= 0;
                1: ref_mode <= ref_mode | 1;
                2: ref_mode <= ref_mode | 2;
                default: ref_mode <= ref_mode;
            endcase
        end
    end

    task automatic check(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(int'(mode_o), ref_mode, "R7 mode tracks model");
            check(int'(energy_o), ref_total, "R6 total tracks model");
        end
    end

    task automatic do_op(input int op, input int sz);
        op_valid = 1'b1;
        op_code  = 3'(op);
        size_sel = 2'(sz);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(int'(mode_o), 0, "R1 mode after reset");
        check(int'(energy_o), 0, "R1 total after reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(int'(energy_o), 0, "R1 total idle after reset");

        do_op(0, 0);  check(int'(energy_o), 11, "R2 reset op cost in idle");
                      check(int'(mode_o), 0, "R2 mode stays idle");
        do_op(3, 3);  check(int'(energy_o), 31, "R11 send idle size3");
                      check(int'(mode_o), 0, "R5 send keeps mode");
        do_op(1, 0);  check(int'(energy_o), 58, "R6 tx enable charged at idle");
                      check(int'(mode_o), 1, "R3 idle to tx");
        do_op(3, 3);  check(int'(energy_o), 267, "R6 send in tx costs 209");
                      check(int'(mode_o), 1, "R5 send keeps tx");
        do_op(1, 1);  check(int'(energy_o), 290, "R6 tx enable in tx");
                      check(int'(mode_o), 1, "R3 tx enable holds tx");
        do_op(2, 2);  check(int'(energy_o), 309, "R6 rx enable in tx");
                      check(int'(mode_o), 3, "R4 tx to duplex");
        do_op(4, 3);  check(int'(energy_o), 416, "R6 receive in duplex");
                      check(int'(mode_o), 3, "R5 receive keeps duplex");
        repeat (3) @(negedge clk);
        check(int'(energy_o), 416, "R7 total holds without strobe");
        check(int'(mode_o), 3, "R7 mode holds without strobe");
        do_op(6, 1);  check(int'(energy_o), 416, "R10 undefined code adds nothing");
                      check(int'(mode_o), 3, "R10 undefined code keeps mode");
        do_op(7, 3);  check(int'(energy_o), 416, "R10 code 7 adds nothing");
        do_op(0, 2);  check(int'(energy_o), 430, "R6 reset op uses pre-op mode");
                      check(int'(mode_o), 0, "R2 duplex to idle");
        do_op(2, 1);  check(int'(energy_o), 448, "R6 rx enable in idle");
                      check(int'(mode_o), 2, "R4 idle to rx");
        do_op(4, 0);  check(int'(energy_o), 521, "R11 receive rx size0");
        do_op(4, 1);  check(int'(energy_o), 604, "R11 receive rx size1");
        do_op(4, 2);  check(int'(energy_o), 697, "R11 receive rx size2");
        do_op(4, 3);  check(int'(energy_o), 808, "R11 receive rx size3");
        do_op(2, 0);  check(int'(mode_o), 2, "R4 rx enable holds rx");
        do_op(1, 0);  check(int'(mode_o), 3, "R3 rx to duplex");
                      check(int'(energy_o), 848, "R6 tx enable in rx");
        clr = 1'b1;
        do_op(3, 3);
        clr = 1'b0;
        check(int'(energy_o), 0, "R9 clear wins over send");
        check(int'(mode_o), 0, "R9 clear forces idle");

        for (int i = 0; i < 400; i++) begin
            clr = (($urandom % 40) == 0);
            if (($urandom % 4) == 0) @(negedge clk);
            else do_op(int'($urandom % 8), int'($urandom % 4));
            clr = 1'b0;
        end

        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        do_op(1, 0);
        for (int i = 0; i < 320; i++) do_op(3, 3);
        check(int'(energy_o), MAXV, "R8 total saturates");
        do_op(3, 3);
        check(int'(energy_o), MAXV, "R8 no wrap after saturation");
        check(int'(mode_o), 1, "R5 long send run keeps tx");

        @(negedge clk);
        finish_run();
    end

endmodule